// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block works out where execution goes next, either after an interrupt or after a restart. An interrupt request carries an 8-bit type number. For each request the block reads a 4-byte entry from the vector table in low memory, using a 16-bit word-read port. It makes two reads, always in the same order:

- The first word becomes the new instruction pointer (offset).
- The second word becomes the new code segment.

A restart request skips the table entirely. It loads a fixed segment:offset pair that points 16 bytes below the top of the 1 MiB address space.

When either path finishes, the block updates the code-segment and instruction-pointer outputs together and raises a one-clock completion strobe. The surrounding core supplies the type number and the restart event. It consumes the new pointer pair when the strobe fires. Stacking of return state, interrupt arbitration and acknowledge cycles all stay outside this block.

Top module: `ivec_fetch_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `mem_req`, `done` and `busy` are 0, `new_cs` is 0xFFFF and `new_ip` is 0x0000.
- R2: When idle, a cycle with `irq_valid`=1 and `restart_req`=0 starts a fetch. From the next cycle, `mem_req` is 1 and `mem_addr` equals type×4, with bits 19..10 zero.
- R3: The cycle after the offset read completes (`mem_req` and `mem_ready` both 1), the block requests the segment word at type×4+2.
- R4: While `mem_ready` is 0 and there is no restart, `mem_req` stays 1 and `mem_addr` holds its value.
- R5: The cycle after the segment read completes, `done` is 1 for exactly one cycle. In that cycle `new_ip` equals the word read at type×4 and `new_cs` equals the word read at type×4+2.
- R6: A cycle with `restart_req`=1 is followed by a cycle with `done`=1, `new_cs`=0xFFFF, `new_ip`=0x0000 and `mem_req`=0. Segment 0xFFFF with offset 0 addresses physical 0xFFFF0.
- R7: A restart arriving while a read is pending abandons the fetch. No further read is issued for that fetch, and the restart values of R6 are delivered.
- R8: While `busy` is 1, `irq_valid` and `irq_type` are ignored. The fetch in progress keeps using the type captured when it began.
- R9: Every requested address lies inside the vector table, 0x00000 to 0x003FF.
- R10: `new_cs` and `new_ip` change only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset |
| restart_req | input | 1 | Restart event; loads the fixed restart pointers |
| irq_valid | input | 1 | Interrupt request strobe, sampled when idle |
| irq_type | input | 8 | Interrupt type number |
| mem_req | output | 1 | Word read request to memory |
| mem_addr | output | 20 | Byte address of the requested word |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the read this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe: new pointers valid |
| new_cs | output | 16 | Loaded code segment |
| new_ip | output | 16 | Loaded instruction pointer |

## Verification
The assertions rely on two properties of the memory side:

- Memory returns `mem_rdata` in the same cycle it raises `mem_ready`.
- `mem_ready` only has meaning while `mem_req` is high.

The bench therefore derives `mem_rdata` combinationally from `mem_addr` with a model function. It drives `mem_ready` only while a request is visible, and for a random number of cycles holds it low to exercise waiting.

Requests and restarts are applied on the falling edge. Some requests are deliberately re-asserted with a different type while busy, so that the ignored inputs stay inside what the block defines.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
  localparam int TYPE_W      = 8;
  localparam int ADDR_W      = 20;
  localparam int DATA_W      = 16;
  localparam int ENTRY_SHIFT = 2;   // 4 bytes per entry
  localparam int WORD_BYTES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_OFF = 2'd1,
    ST_RD_SEG = 2'd2,
    ST_DONE   = 2'd3
  } ivf_state_e;

  // Byte address of one word of a table entry: base + type*4 (+2 for segment)
  function automatic logic [ADDR_W-1:0] entry_word_addr(
    input logic [ADDR_W-1:0] base,
    input logic [TYPE_W-1:0] typ,
    input logic              seg_sel
  );
    logic [ADDR_W-1:0] ofs;
    ofs = ADDR_W'(typ) << ENTRY_SHIFT;
    if (seg_sel) ofs = ofs + ADDR_W'(WORD_BYTES);
    return base + ofs;
  endfunction
endpackage

// File: rtl/ivf_addr_gen.sv
module ivf_addr_gen #(
  parameter int TYPE_W = ivf_pkg::TYPE_W,
  parameter int ADDR_W = ivf_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
  input  logic [TYPE_W-1:0] typ,
  input  logic              seg_sel,
  output logic [ADDR_W-1:0] addr
);
  always_comb addr = ivf_pkg::entry_word_addr(TABLE_BASE, typ, seg_sel);
endmodule

// File: rtl/ivf_ctrl.sv
module ivf_ctrl
  import ivf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart_req,
  input  logic irq_valid,
  input  logic mem_ready,
  output logic fetch_start,
  output logic off_accept,
  output logic seg_accept,
  output logic mem_req,
  output logic seg_sel,
  output logic busy,
  output logic done
);
  ivf_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (irq_valid) state_d = ST_RD_OFF;
      ST_RD_OFF: if (mem_ready) state_d = ST_RD_SEG;
      ST_RD_SEG: if (mem_ready) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    // restart wins over everything, including a fetch in flight
    if (restart_req) state_d = ST_DONE;
  end

  always_comb begin
    mem_req     = (state_q == ST_RD_OFF) || (state_q == ST_RD_SEG);
    seg_sel     = (state_q == ST_RD_SEG);
    busy        = (state_q != ST_IDLE);
    done        = (state_q == ST_DONE);
    fetch_start = (state_q == ST_IDLE)   && irq_valid && !restart_req;
    off_accept  = (state_q == ST_RD_OFF) && mem_ready && !restart_req;
    seg_accept  = (state_q == ST_RD_SEG) && mem_ready && !restart_req;
  end
endmodule

// File: rtl/ivf_ptr_regs.sv
module ivf_ptr_regs #(
  parameter int TYPE_W = ivf_pkg::TYPE_W,
  parameter int DATA_W = ivf_pkg::DATA_W,
  parameter logic [DATA_W-1:0] RESTART_CS = 16'hFFFF,
  parameter logic [DATA_W-1:0] RESTART_IP = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_start,
  input  logic              off_accept,
  input  logic              seg_accept,
  input  logic              restart_load,
  input  logic [TYPE_W-1:0] irq_type,
  input  logic [DATA_W-1:0] rdata,
  output logic [TYPE_W-1:0] type_q,
  output logic [DATA_W-1:0] new_cs,
  output logic [DATA_W-1:0] new_ip
);
  logic [DATA_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      off_q  <= '0;
    end else begin
      if (fetch_start) type_q <= irq_type;
      if (off_accept)  off_q  <= rdata;
    end
  end

  // Both visible pointers move on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_cs <= RESTART_CS;
      new_ip <= RESTART_IP;
    end else if (restart_load) begin
      new_cs <= RESTART_CS;
      new_ip <= RESTART_IP;
    end else if (seg_accept) begin
      new_cs <= rdata;
      new_ip <= off_q;
    end
  end
endmodule

// File: rtl/ivec_fetch_seq.sv
module ivec_fetch_seq #(
  parameter int TYPE_W = ivf_pkg::TYPE_W,
  parameter int ADDR_W = ivf_pkg::ADDR_W,
  parameter int DATA_W = ivf_pkg::DATA_W,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0,
  parameter logic [DATA_W-1:0] RESTART_CS = 16'hFFFF,
  parameter logic [DATA_W-1:0] RESTART_IP = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_req,
  input  logic              irq_valid,
  input  logic [TYPE_W-1:0] irq_type,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] new_cs,
  output logic [DATA_W-1:0] new_ip
);
  // internal events, named for the checker
  logic              fetch_start;
  logic              off_accept;
  logic              seg_accept;
  logic              seg_sel;
  logic [TYPE_W-1:0] type_q;

  ivf_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_req (restart_req),
    .irq_valid   (irq_valid),
    .mem_ready   (mem_ready),
    .fetch_start (fetch_start),
    .off_accept  (off_accept),
    .seg_accept  (seg_accept),
    .mem_req     (mem_req),
    .seg_sel     (seg_sel),
    .busy        (busy),
    .done        (done)
  );

  ivf_ptr_regs #(
    .TYPE_W     (TYPE_W),
    .DATA_W     (DATA_W),
    .RESTART_CS (RESTART_CS),
    .RESTART_IP (RESTART_IP)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_start  (fetch_start),
    .off_accept   (off_accept),
    .seg_accept   (seg_accept),
    .restart_load (restart_req),
    .irq_type     (irq_type),
    .rdata        (mem_rdata),
    .type_q       (type_q),
    .new_cs       (new_cs),
    .new_ip       (new_ip)
  );

  ivf_addr_gen #(
    .TYPE_W     (TYPE_W),
    .ADDR_W     (ADDR_W),
    .TABLE_BASE (TABLE_BASE)
  ) u_addr (
    .typ     (type_q),
    .seg_sel (seg_sel),
    .addr    (mem_addr)
  );
endmodule

// File: rtl/ivf_checker.sv
module ivf_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] RESTART_CS = 16'hFFFF,
  parameter logic [DATA_W-1:0] RESTART_IP = 16'h0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart_req,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              done,
  input logic              busy,
  input logic [DATA_W-1:0] new_cs,
  input logic [DATA_W-1:0] new_ip,
  input logic              off_accept,
  input logic              seg_accept
);
  localparam logic [ADDR_W-1:0] TABLE_END = ADDR_W'(1024);

  assert_addr_in_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr < TABLE_END));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !restart_req) |=> (mem_req && $stable(mem_addr)));

  assert_seg_after_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    off_accept |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(2)));

  assert_done_after_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_accept |=> done);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart_req) |=> !done);

  assert_restart_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> (done && !mem_req && new_cs == RESTART_CS && new_ip == RESTART_IP));

  assert_ptr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_cs) && $stable(new_ip)));

  assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done) |-> busy);
endmodule

bind ivec_fetch_seq ivf_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .RESTART_CS (RESTART_CS),
  .RESTART_IP (RESTART_IP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart_req (restart_req),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_ready   (mem_ready),
  .done        (done),
  .busy        (busy),
  .new_cs      (new_cs),
  .new_ip      (new_ip),
  .off_accept  (off_accept),
  .seg_accept  (seg_accept)
);

// File: tb/ivec_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module ivec_fetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart_req = 1'b0;
  logic        irq_valid = 1'b0;
  logic [7:0]  irq_type = 8'h00;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        mem_ready = 1'b0;
  logic        busy, done;
  logic [15:0] new_cs, new_ip;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  ivec_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .restart_req(restart_req),
    .irq_valid(irq_valid), .irq_type(irq_type),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .busy(busy), .done(done),
    .new_cs(new_cs), .new_ip(new_ip)
  );

  // memory model: every table word has a distinct content
  function automatic logic [15:0] table_word(input logic [19:0] a);
    logic [31:0] h;
    h = (32'(a) * 32'h9E37) ^ 32'h3C5A;
    return h[15:0] ^ {6'd0, a[9:0]};
  endfunction

  function automatic logic [19:0] want_addr(input logic [7:0] t, input bit seg);
    return {10'd0, t, seg, 1'b0};
  endfunction

  assign mem_rdata = mem_req ? table_word(mem_addr) : 16'h0000;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Run one interrupt fetch; max_wait bounds the ready delay
  task automatic run_irq(input logic [7:0] t, input int max_wait, input bit poke_busy);
    int phase = 0;
    int waits = 0;
    int guard = 0;
    @(negedge clk);
    irq_valid = 1'b1; irq_type = t;
    @(negedge clk);
    irq_valid = poke_busy;            // R8: retrigger with another type while busy
    irq_type  = t ^ 8'h5A;
    while (!done && guard < 200) begin
      guard++;
      if (mem_req) begin
        check(mem_addr == want_addr(t, phase == 1), phase == 0 ? "R2" : "R3",
              "read address", 32'(mem_addr), 32'(want_addr(t, phase == 1)));
        if (waits >= max_wait || ($urandom % 3) == 0) begin
          mem_ready = 1'b1; waits = 0; phase++;
        end else begin
          mem_ready = 1'b0; waits++;
        end
      end else mem_ready = 1'b0;
      @(negedge clk);
    end
    mem_ready = 1'b0; irq_valid = 1'b0;
    check(done == 1'b1, "R5", "done after segment", 32'(done), 1);
    check(new_ip == table_word(want_addr(t, 0)), "R5", "new_ip",
          32'(new_ip), 32'(table_word(want_addr(t, 0))));
    check(new_cs == table_word(want_addr(t, 1)), "R5", "new_cs",
          32'(new_cs), 32'(table_word(want_addr(t, 1))));
    @(negedge clk);
    check(done == 1'b0, "R5", "done single cycle", 32'(done), 0);
    check(mem_req == 1'b0 && busy == 1'b0, "R8", "idle after done",
          32'({mem_req, busy}), 0);
  endtask

  task automatic check_restart_vals(input string req);
    check(done == 1'b1, req, "restart done", 32'(done), 1);
    check(new_cs == 16'hFFFF && new_ip == 16'h0000, req, "restart pointers",
          32'({new_cs, new_ip}), 32'hFFFF0000);
    check(mem_req == 1'b0, req, "no read on restart", 32'(mem_req), 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000 && !finished) begin
      @(posedge clk); cycles++;
    end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] held_cs, held_ip;
    logic [19:0] held_addr;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check(mem_req == 0 && done == 0 && busy == 0, "R1", "reset controls",
          32'({mem_req, done, busy}), 0);
    check(new_cs == 16'hFFFF && new_ip == 16'h0000, "R1", "reset pointers",
          32'({new_cs, new_ip}), 32'hFFFF0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req == 0 && done == 0 && busy == 0, "R1", "after reset release",
          32'({mem_req, done, busy}), 0);

    // directed corners: lowest and highest type, no wait and long wait
    run_irq(8'h00, 0, 1'b0);
    run_irq(8'hFF, 6, 1'b1);

    // R4: hold ready low for several cycles, address must hold
    @(negedge clk); irq_valid = 1'b1; irq_type = 8'h21;
    @(negedge clk); irq_valid = 1'b0;
    held_addr = mem_addr;
    repeat (4) @(negedge clk);
    check(mem_req == 1'b1 && mem_addr == held_addr, "R4", "request held",
          32'({mem_req, mem_addr}), 32'({1'b1, held_addr}));
    // R7: restart while the offset read is pending
    restart_req = 1'b1;
    @(negedge clk); restart_req = 1'b0;
    check_restart_vals("R7");
    @(negedge clk);
    check(mem_req == 1'b0 && done == 1'b0, "R7", "fetch abandoned",
          32'({mem_req, done}), 0);

    // R6: restart from idle
    run_irq(8'h40, 2, 1'b0);
    @(negedge clk); restart_req = 1'b1;
    @(negedge clk); restart_req = 1'b0;
    check_restart_vals("R6");
    held_cs = new_cs; held_ip = new_ip;
    repeat (3) @(negedge clk);
    check(new_cs == held_cs && new_ip == held_ip, "R10", "pointers hold when idle",
          32'({new_cs, new_ip}), 32'({held_cs, held_ip}));

    // restart together with a request: restart wins (R6)
    irq_valid = 1'b1; irq_type = 8'h13; restart_req = 1'b1;
    @(negedge clk); irq_valid = 1'b0; restart_req = 1'b0;
    check_restart_vals("R6");
    @(negedge clk);
    check(busy == 1'b0, "R6", "no fetch after combined restart", 32'(busy), 0);

    // random fetches, the range check of R9 rides on the address checks
    for (int i = 0; i < 24; i++) begin
      logic [7:0] t;
      t = 8'($urandom);
      run_irq(t, int'($urandom % 5), bit'($urandom % 2));
      check(mem_addr[19:10] == 10'd0 || !mem_req, "R9", "address in table",
            32'(mem_addr), 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule